// File: doc/BRIEF.md
# Word-to-Byte SDRAM Burst Sequencer

This block sits between a host that issues 32-bit word accesses and an SDRAM device with an 8-bit data bus. A start pulse from the host turns into a fixed command sequence on the SDRAM pins. First a row activate with the bank and row. Then a read or write with auto-precharge at the word-aligned column. The burst then runs for four beats, and a precharge wait follows before the block reports completion with a one-cycle done pulse.

On a write, the four bytes of the host word go out most significant byte first. The data-mask pin blocks every beat whose byte enable is clear, so a single-byte write changes only its own column. On a read, the four bytes that arrive one CAS latency after their beats are shifted into one word in beat order. Each byte keeps its own lane and is never copied into the others. A parameter selects normal or reversed numbering of the SDRAM address pins, so boards that wire the address bus in the opposite order work without rework.

The host address splits, from most to least significant bit, into bank, row and column fields. The column field includes the two byte-offset bits. Power-up initialisation and refresh belong to other logic. The SDRAM mode register is assumed to hold burst length 4 with sequential order.

Top module: `wb_burst_seq`

## Requirements
- R1: In the cycle after a start pulse is accepted, the pins carry ACTIVE with the bank and row fields. The column command follows exactly T_RCD cycles after ACTIVE. Every other cycle carries NOP. Chip select is always low, and {ras_n,cas_n,we_n} is 011 for ACTIVE, 101 for READ, 100 for WRITE and 111 for NOP.
- R2: During the column command, bank pins carry the bank field. Logical address bits [COL_W-1:0] carry the column field with bits 1:0 forced to zero. Logical bit 10 is high to request auto-precharge.
- R3: A write drives the data bus on four consecutive cycles, starting with the WRITE command. Beat k (0..3) carries host data bits [31-8k:24-8k], so 0x01020304 appears as 01, 02, 03, 04.
- R4: On write beat k, the data mask is high exactly when byte-enable bit 3-k is clear, so a write with all enables set masks nothing. The mask is low on the four read beats and high in every other cycle.
- R5: The data-bus output enable is high only on the four write beats. It is never high during a read or while idle.
- R6: The byte presented on the read-data input CAS_LAT cycles after read beat k lands in host read data bits [31-8k:24-8k].
- R7: Done is a one-cycle pulse. It occurs 1+T_RCD+4+T_RP cycles after the accepting edge for a write, and CAS_LAT cycles later than that for a read. Read data is valid in the done cycle.
- R8: For the T_RP cycles before done, only NOP is issued. A start pulse is ignored while a request is in progress, including the done cycle, and has no effect on the pins or memory contents. A start in the cycle after done is accepted.
- R9: With REVERSE_PINS=0, logical address bit i drives pin i. With REVERSE_PINS=1, it drives pin A_W-1-i.
- R10: During and after reset, before any request, the pins carry NOP, the mask is high, the output enable is low, done is low and read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostStart | input | 1 | One-cycle request pulse |
| hostAddr | input | BANK_W+ROW_W+COL_W | Byte address: bank, row, column (low two bits are the byte offset) |
| hostWrite | input | 1 | 1 for write, 0 for read |
| hostByteEn | input | 4 | Byte enable, bit i selects host data bits [8i+7:8i] |
| hostWData | input | 32 | Write data |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRData | output | 32 | Read data, valid with hostDone |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_W | Bank address |
| sdAddr | output | A_W | Multiplexed row/column address pins |
| sdDqm | output | 1 | Data mask |
| sdDqOut | output | 8 | Data bus, outgoing byte |
| sdDqOe | output | 1 | Data bus output enable |
| sdDqIn | input | 8 | Data bus, incoming byte |

## Verification
On every cycle, the embedded assertions check these properties:
- ACTIVE is always followed by NOP.
- The bus is only turned around on a WRITE command and is never driven under a READ.
- Column commands are aligned and carry auto-precharge.
- A full-word write is never masked.
- Each captured byte enters the low end of the read shift register.
- Done never lasts two cycles.
- A busy request never restarts the sequence.

Only the bench scenarios can show the remaining behaviour:
- Bytes written through partial byte enables come back in the correct lanes after a later read.
- The command and mask timing matches the parameters cycle by cycle.
- Starts arriving mid-burst leave memory unchanged.
- The reversed pin instance presents the mirrored address.

// File: rtl/wb_burst_pkg.sv
package wb_burst_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmdKind_e;

  typedef enum logic [1:0] {
    ASEL_NONE = 2'd0,
    ASEL_ROW  = 2'd1,
    ASEL_COL  = 2'd2
  } addrSel_e;

  // Strobes from the sequencer to the datapath, valid for the current cycle.
  typedef struct packed {
    logic     latch;    // capture host request this cycle
    cmdKind_e cmd;      // command to place on the pins
    addrSel_e addrSel;  // which field goes onto the address pins
    logic     wrBeat;   // write burst beat in progress
    logic     rdBeat;   // read burst beat in progress
    logic [1:0] beat;   // beat index within the burst
    logic     capture;  // sample the incoming data byte
    logic     done;     // completion pulse
  } ctrlStrobe_t;

endpackage

// File: rtl/wb_burst_ctrl.sv
module wb_burst_ctrl
  import wb_burst_pkg::*;
#(
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int CAS_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostStart,
  input  logic        hostWrite,
  output ctrlStrobe_t strb
);

  localparam int MAX_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int MAX_B   = (MAX_A > CAS_LAT) ? MAX_A : CAS_LAT;
  localparam int CNT_MAX = (MAX_B > 4) ? MAX_B : 4;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_BURST, ST_TAIL, ST_PRE, ST_DONE
  } state_e;

  state_e             state;
  logic [CNT_W-1:0]   cnt;
  logic               wrQ;
  logic [CAS_LAT-1:0] capPipe;
  logic               rdBeatNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wrQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (hostStart) begin
          state <= ST_ACT;
          wrQ   <= hostWrite;
        end
        ST_ACT: begin
          state <= ST_RCD;
          cnt   <= CNT_W'(T_RCD - 2);
        end
        ST_RCD: begin
          if (cnt == '0) state <= ST_BURST;
          else           cnt   <= cnt - 1'b1;
        end
        ST_BURST: begin
          if (cnt == CNT_W'(3)) begin
            if (wrQ) begin
              state <= ST_PRE;
              cnt   <= CNT_W'(T_RP - 1);
            end else begin
              state <= ST_TAIL;
              cnt   <= CNT_W'(CAS_LAT - 1);
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt == '0) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rdBeatNow = (state == ST_BURST) && !wrQ;

  // Read capture point trails each read beat by the CAS latency.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capPipe <= '0;
    else       capPipe <= {capPipe[CAS_LAT-2:0], rdBeatNow};
  end

  always_comb begin
    strb         = '0;
    strb.cmd     = CMD_NOP;
    strb.addrSel = ASEL_NONE;
    strb.latch   = (state == ST_IDLE) && hostStart;
    strb.wrBeat  = (state == ST_BURST) && wrQ;
    strb.rdBeat  = rdBeatNow;
    strb.beat    = cnt[1:0];
    strb.capture = capPipe[CAS_LAT-1];
    strb.done    = (state == ST_DONE);
    if (state == ST_ACT) begin
      strb.cmd     = CMD_ACT;
      strb.addrSel = ASEL_ROW;
    end else if (state == ST_BURST && cnt == '0) begin
      strb.cmd     = wrQ ? CMD_WR : CMD_RD;
      strb.addrSel = ASEL_COL;
    end
  end

  // R7: completion lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done);

  // R1: row activate is followed by a NOP (T_RCD of at least 2)
  a_r1_nop_after_act: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmd == CMD_ACT) |=> (strb.cmd == CMD_NOP));

  // R8: a start while busy never restarts the sequence
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && hostStart) |=> (state != ST_ACT));

endmodule

// File: rtl/wb_burst_dp.sv
module wb_burst_dp
  import wb_burst_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int A_W          = 12,
  parameter bit REVERSE_PINS = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strb,
  input  logic [BANK_W+ROW_W+COL_W-1:0] hostAddr,
  input  logic [3:0]                    hostByteEn,
  input  logic [31:0]                   hostWData,
  input  logic [7:0]                    sdDqIn,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBa,
  output logic [A_W-1:0]                sdAddr,
  output logic                          sdDqm,
  output logic [7:0]                    sdDqOut,
  output logic                          sdDqOe,
  output logic                          hostDone,
  output logic [31:0]                   hostRData
);

  localparam int HADDR_W = BANK_W + ROW_W + COL_W;
  localparam int AP_BIT  = 10;

  logic [HADDR_W-1:0] addrQ;
  logic [3:0]         beQ;
  logic [31:0]        wdataQ;
  logic [31:0]        rdShift;
  logic [A_W-1:0]     logAddr;
  logic [1:0]         lane;
  logic [ROW_W-1:0]   rowQ;
  logic [BANK_W-1:0]  bankQ;
  logic               unusedByteOffset;

  assign rowQ             = addrQ[COL_W +: ROW_W];
  assign bankQ            = addrQ[COL_W+ROW_W +: BANK_W];
  assign unusedByteOffset = ^addrQ[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      beQ    <= '0;
      wdataQ <= '0;
    end else if (strb.latch) begin
      addrQ  <= hostAddr;
      beQ    <= hostByteEn;
      wdataQ <= hostWData;
    end
  end

  // Read bytes arrive first-beat-first; shifting left packs beat 0 at the top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdShift <= '0;
    else if (strb.capture) rdShift <= {rdShift[23:0], sdDqIn};
  end

  always_comb begin
    logAddr = '0;
    case (strb.addrSel)
      ASEL_ROW: logAddr[ROW_W-1:0] = rowQ;
      ASEL_COL: begin
        logAddr[COL_W-1:2] = addrQ[COL_W-1:2];
        logAddr[AP_BIT]    = 1'b1;
      end
      default: logAddr = '0;
    endcase
  end

  generate
    if (REVERSE_PINS) begin : g_revPins
      for (genvar i = 0; i < A_W; i++) begin : g_bit
        assign sdAddr[i] = logAddr[A_W-1-i];
      end
    end else begin : g_fwdPins
      assign sdAddr = logAddr;
    end
  endgenerate

  always_comb begin
    case (strb.cmd)
      CMD_ACT: {sdRasN, sdCasN, sdWeN} = 3'b011;
      CMD_RD:  {sdRasN, sdCasN, sdWeN} = 3'b101;
      CMD_WR:  {sdRasN, sdCasN, sdWeN} = 3'b100;
      default: {sdRasN, sdCasN, sdWeN} = 3'b111;
    endcase
  end

  assign sdCsN = 1'b0;
  assign sdBa  = (strb.addrSel != ASEL_NONE) ? bankQ : '0;

  // Beat k carries host lane 3-k: most significant byte first.
  assign lane    = ~strb.beat;
  assign sdDqOut = strb.wrBeat ? wdataQ[{lane, 3'b000} +: 8] : 8'h00;
  assign sdDqOe  = strb.wrBeat;

  always_comb begin
    if (strb.wrBeat)      sdDqm = ~beQ[lane];
    else if (strb.rdBeat) sdDqm = 1'b0;
    else                  sdDqm = 1'b1;
  end

  assign hostDone  = strb.done;
  assign hostRData = rdShift;

  // R3: bus turnaround happens only together with a WRITE command
  a_r3_drive_with_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdDqOe) |-> (sdRasN && !sdCasN && !sdWeN));

  // R5: never drive the bus under a READ command
  a_r5_no_drive_read: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCasN && sdWeN) |-> !sdDqOe);

  // R2: column commands are word aligned and auto-precharge
  a_r2_col_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCasN) |-> (logAddr[1:0] == 2'b00 && logAddr[AP_BIT]));

  // R4: full-word writes are never masked
  a_r4_full_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    (sdDqOe && beQ == 4'hF) |-> !sdDqm);

  // R6: each captured byte enters the low lane of the shift register
  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (hostRData[7:0] == $past(sdDqIn)));

endmodule

// File: rtl/wb_burst_seq.sv
module wb_burst_seq
  import wb_burst_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int A_W          = 12,
  parameter int CAS_LAT      = 2,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter bit REVERSE_PINS = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hostStart,
  input  logic [BANK_W+ROW_W+COL_W-1:0] hostAddr,
  input  logic                          hostWrite,
  input  logic [3:0]                    hostByteEn,
  input  logic [31:0]                   hostWData,
  output logic                          hostDone,
  output logic [31:0]                   hostRData,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBa,
  output logic [A_W-1:0]                sdAddr,
  output logic                          sdDqm,
  output logic [7:0]                    sdDqOut,
  output logic                          sdDqOe,
  input  logic [7:0]                    sdDqIn
);

  ctrlStrobe_t strb;

  wb_burst_ctrl #(
    .T_RCD  (T_RCD),
    .T_RP   (T_RP),
    .CAS_LAT(CAS_LAT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostStart(hostStart),
    .hostWrite(hostWrite),
    .strb     (strb)
  );

  wb_burst_dp #(
    .BANK_W      (BANK_W),
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .A_W         (A_W),
    .REVERSE_PINS(REVERSE_PINS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostAddr  (hostAddr),
    .hostByteEn(hostByteEn),
    .hostWData (hostWData),
    .sdDqIn    (sdDqIn),
    .sdCsN     (sdCsN),
    .sdRasN    (sdRasN),
    .sdCasN    (sdCasN),
    .sdWeN     (sdWeN),
    .sdBa      (sdBa),
    .sdAddr    (sdAddr),
    .sdDqm     (sdDqm),
    .sdDqOut   (sdDqOut),
    .sdDqOe    (sdDqOe),
    .hostDone  (hostDone),
    .hostRData (hostRData)
  );

endmodule

// File: tb/wb_burst_seq_test.sv
`timescale 1ns/1ps
module wb_burst_seq_test;

  localparam int BANK_W = 2, ROW_W = 12, COL_W = 10, A_W = 12;
  localparam int CL = 2, T_RCD = 2, T_RP = 2;
  localparam int HW = BANK_W + ROW_W + COL_W;
  localparam int CCYC = 1 + T_RCD;          // column command cycle

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostStart = 1'b0, hostWrite = 1'b0;
  logic [HW-1:0] hostAddr = '0;
  logic [3:0] hostByteEn = '0;
  logic [31:0] hostWData = '0;
  logic [7:0] sdDqIn = 8'hEE;

  logic hostDone, sdCsN, sdRasN, sdCasN, sdWeN, sdDqm, sdDqOe;
  logic [31:0] hostRData;
  logic [BANK_W-1:0] sdBa;
  logic [A_W-1:0] sdAddr;
  logic [7:0] sdDqOut;

  logic rDone, rCsN, rRasN, rCasN, rWeN, rDqm, rDqOe;
  logic [31:0] rRData;
  logic [BANK_W-1:0] rBa;
  logic [A_W-1:0] rAddr;
  logic [7:0] rDqOut;

  always #5 clk = ~clk;

  wb_burst_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W),
    .CAS_LAT(CL), .T_RCD(T_RCD), .T_RP(T_RP), .REVERSE_PINS(1'b0)) uut (
    .clk(clk), .rstN(rstN), .hostStart(hostStart), .hostAddr(hostAddr),
    .hostWrite(hostWrite), .hostByteEn(hostByteEn), .hostWData(hostWData),
    .hostDone(hostDone), .hostRData(hostRData), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn));

  wb_burst_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W),
    .CAS_LAT(CL), .T_RCD(T_RCD), .T_RP(T_RP), .REVERSE_PINS(1'b1)) uutRev (
    .clk(clk), .rstN(rstN), .hostStart(hostStart), .hostAddr(hostAddr),
    .hostWrite(hostWrite), .hostByteEn(hostByteEn), .hostWData(hostWData),
    .hostDone(rDone), .hostRData(rRData), .sdCsN(rCsN), .sdRasN(rRasN),
    .sdCasN(rCasN), .sdWeN(rWeN), .sdBa(rBa), .sdAddr(rAddr), .sdDqm(rDqm),
    .sdDqOut(rDqOut), .sdDqOe(rDqOe), .sdDqIn(sdDqIn));

  int vectors = 0, miscompares = 0, cycles = 0;
  bit started = 1'b0;

  function automatic logic [7:0] fillByte(int a);
    return 8'((a * 7 + 60) ^ (a >>> 8));
  endfunction

  function automatic logic [A_W-1:0] bitRev(logic [A_W-1:0] v);
    logic [A_W-1:0] r;
    for (int i = 0; i < A_W; i++) r[i] = v[A_W-1-i];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, cycles, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // ---------------- behavioural reference of the host request -------------
  logic [7:0] refMem [int];
  int mPhase = -1, mLast = 0;
  bit mWr = 1'b0;
  int mBase = 0;
  logic [3:0] mBe = '0;
  logic [31:0] mData = '0, mExpRd = '0;

  function automatic logic [7:0] refRead(int a);
    if (refMem.exists(a)) return refMem[a];
    return fillByte(a);
  endfunction

  always @(posedge clk) begin
    cycles++;
    started = 1'b1;
    if (!rstN) mPhase = -1;
    else if (mPhase < 0) begin
      if (hostStart) begin
        mWr = hostWrite; mBe = hostByteEn; mData = hostWData;
        mBase = int'({hostAddr[HW-1:2], 2'b00});
        mPhase = 1;
        mLast = mWr ? (CCYC + 4 + T_RP) : (CCYC + 4 + CL + T_RP);
        if (mWr) begin
          for (int i = 0; i < 4; i++)
            if (mBe[i]) refMem[mBase + 3 - i] = mData[8*i +: 8];
        end else begin
          for (int k = 0; k < 4; k++) mExpRd[31-8*k -: 8] = refRead(mBase + k);
        end
      end
    end else if (mPhase == mLast) mPhase = -1;
    else mPhase++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  // ---------------- SDRAM device model driven by uut pins ------------------
  logic [7:0] devMem [int];
  int devRow = 0, devBank = 0, wrBase = 0, wrCnt = 4, rdBase = 0, rdTimer = 99;

  function automatic logic [7:0] devRead(int a);
    if (devMem.exists(a)) return devMem[a];
    return fillByte(a);
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if ({sdRasN, sdCasN, sdWeN} == 3'b011) begin
        devRow = int'(sdAddr[ROW_W-1:0]); devBank = int'(sdBa);
      end
      if ({sdRasN, sdCasN, sdWeN} == 3'b100) begin
        wrBase = (devBank << (ROW_W + COL_W)) | (devRow << COL_W) | int'(sdAddr[COL_W-1:0]);
        wrCnt = 0;
      end
      if ({sdRasN, sdCasN, sdWeN} == 3'b101) begin
        rdBase = (devBank << (ROW_W + COL_W)) | (devRow << COL_W) | int'(sdAddr[COL_W-1:0]);
        rdTimer = 0;
      end
      if (sdDqOe && wrCnt < 4) begin
        if (!sdDqm) devMem[wrBase + wrCnt] = sdDqOut;
        wrCnt++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rdTimer < 99) rdTimer++;
    if (rdTimer >= CL && rdTimer < CL + 4) sdDqIn = devRead(rdBase + rdTimer - CL);
    else sdDqIn = 8'hEE;
  end

  // ---------------- cycle-by-cycle comparison ------------------------------
  always @(negedge clk) begin
    if (started) begin
      automatic int p = mPhase;
      automatic int k = p - CCYC;
      automatic bit inBurst = (p >= CCYC) && (p <= CCYC + 3);
      automatic logic [2:0] eCmd = 3'b111;
      automatic logic [BANK_W-1:0] eBa = '0;
      automatic logic [A_W-1:0] eAddr = '0;
      automatic logic eOe = mWr && inBurst && p > 0;
      automatic logic eDqm = 1'b1;
      automatic logic eDone = (p > 0) && (p == mLast);
      automatic string tCmd = (p < 0) ? "R10" : ((p > CCYC + 3) ? "R8" : "R1");
      if (p == 1) begin
        eCmd = 3'b011; eBa = BANK_W'(mBase >> (ROW_W + COL_W));
        eAddr[ROW_W-1:0] = ROW_W'(mBase >> COL_W);
      end
      if (p == CCYC) begin
        eCmd = mWr ? 3'b100 : 3'b101; eBa = BANK_W'(mBase >> (ROW_W + COL_W));
        eAddr[COL_W-1:0] = COL_W'(mBase); eAddr[10] = 1'b1;
      end
      if (inBurst && p > 0) eDqm = mWr ? ~mBe[3-k] : 1'b0;
      chk({sdCsN, sdRasN, sdCasN, sdWeN} == {1'b0, eCmd}, tCmd, "command",
          {28'd0, sdCsN, sdRasN, sdCasN, sdWeN}, {29'd0, eCmd});
      chk(sdBa == eBa, (p == CCYC) ? "R2" : "R1", "bank", 32'(sdBa), 32'(eBa));
      chk(sdAddr == eAddr, (p == CCYC) ? "R2" : "R1", "address", 32'(sdAddr), 32'(eAddr));
      chk(sdDqOe == eOe, (p < 0) ? "R10" : "R5", "output enable", 32'(sdDqOe), 32'(eOe));
      if (eOe) chk(sdDqOut == mData[31-8*k -: 8], "R3", "write byte",
                   32'(sdDqOut), 32'(mData[31-8*k -: 8]));
      chk(sdDqm == eDqm, (p < 0) ? "R10" : "R4", "data mask", 32'(sdDqm), 32'(eDqm));
      chk(hostDone == eDone, (p < 0) ? "R10" : "R7", "done", 32'(hostDone), 32'(eDone));
      if (eDone && !mWr) chk(hostRData == mExpRd, "R6", "read word", hostRData, mExpRd);
      chk(rAddr == bitRev(eAddr), "R9", "reversed address", 32'(rAddr), 32'(bitRev(eAddr)));
      chk({rCsN, rRasN, rCasN, rWeN, rBa, rDqm, rDqOe, rDone} ==
          {sdCsN, sdRasN, sdCasN, sdWeN, sdBa, sdDqm, sdDqOe, sdDone_w()},
          "R9", "reversed instance control", 32'(rRasN), 32'(sdRasN));
    end
  end

  function automatic logic sdDone_w();
    return hostDone;
  endfunction

  // ---------------- stimulus -------------------------------------------------
  task automatic setReq(bit wr, int addr, logic [3:0] be, logic [31:0] d);
    hostWrite = wr; hostAddr = HW'(addr); hostByteEn = be; hostWData = d;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!hostDone);
  endtask

  task automatic doTxn(bit wr, int addr, logic [3:0] be, logic [31:0] d);
    @(posedge clk); #2;
    setReq(wr, addr, be, d); hostStart = 1'b1;
    @(posedge clk); #2;
    hostStart = 1'b0;
    waitDone();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk(hostRData == 32'd0, "R10", "read data after reset", hostRData, 32'd0);

    // R6: unwritten location returns four distinct bytes, not a replica
    doTxn(1'b0, 'h000100, 4'h0, 32'd0);
    // R3 R4: full word, MSB first, no mask; then read back
    doTxn(1'b1, 'h000000, 4'hF, 32'h01020304);
    doTxn(1'b0, 'h000000, 4'h0, 32'd0);
    // R2 R4: single-byte writes at each offset, burst still starts aligned
    for (int off = 0; off < 4; off++) begin
      doTxn(1'b1, 'h000040 + off, 4'(1 << (3 - off)), {4{8'hA0 + 8'(off)}});
      doTxn(1'b0, 'h000040 + off, 4'h0, 32'd0);
    end
    // R4: sparse enables at the top of the address space
    doTxn(1'b1, 'hFFFFFF, 4'b0101, 32'hDEADBEEF);
    doTxn(1'b0, 'hFFFFFC, 4'h0, 32'd0);
    // R4: no enables, nothing changes
    doTxn(1'b1, 'h000000, 4'h0, 32'hFFFFFFFF);
    doTxn(1'b0, 'h000000, 4'h0, 32'd0);

    // R8: starts while busy and during the done cycle are ignored
    @(posedge clk); #2;
    setReq(1'b0, 'h000000, 4'h0, 32'd0); hostStart = 1'b1;
    @(posedge clk); #2 hostStart = 1'b0;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #2;
      setReq(1'b1, 'h000200, 4'hF, 32'h55AA55AA); hostStart = 1'b1;
      @(posedge clk); #2 hostStart = 1'b0;
    end
    waitDone();
    hostStart = 1'b1;
    @(posedge clk); #2 hostStart = 1'b0;
    doTxn(1'b0, 'h000200, 4'h0, 32'd0);

    // R8: start held across done is taken in the cycle after done
    @(posedge clk); #2;
    setReq(1'b1, 'h123454, 4'hF, 32'hC0FFEE11); hostStart = 1'b1;
    @(posedge clk); #2;
    setReq(1'b0, 'h123454, 4'h0, 32'd0);
    waitDone();
    @(posedge clk); @(posedge clk); #2 hostStart = 1'b0;
    waitDone();

    // mixed traffic over a small address window
    for (int n = 0; n < 24; n++) begin
      automatic int a = int'({$urandom_range(3, 0), 10'd0, 2'd0, 10'(($urandom_range(15, 0)) << 2)})
                        | $urandom_range(3, 0);
      doTxn(1'($urandom_range(1, 0)), a, 4'($urandom_range(15, 0)), $urandom());
    end

    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule